// File: doc/BRIEF.md
# Tuner Synthesizer Serial Control Interface

This block is the two-wire serial slave that holds the control settings of a tuner frequency synthesizer. A bus master programs it with one write of five bytes: the slave address, two bytes of the programmable divider word, one control byte and one band-switch byte. The control byte sets the charge pump current, three test bits, the reference divider select and an oscillator disable bit. The band byte sets three band-switch port outputs. The settings are held in a shadow copy while the bytes arrive. They are moved to the outputs together, and only when the acknowledge of the last data byte ends, so the synthesizer never runs with half of a new setting.

On a read the slave returns a status byte. It holds a power-on flag, the loop lock flag, the automatic low-current charge pump flag, two fixed ones and the three-bit code of a five-level converter. A two-bit strap input picks one of four slave addresses, so up to four such synthesizers can share one bus. SCL and SDA are oversampled in the system clock domain. SDA is driven through an open-drain pull-low enable.

Top module: `tsyn_ctrl`

## Requirements
- R1: After reset every setting output is 0, the SDA pull-low enable is 0 and the power flag is 1.
- R2: The slave acknowledges only an address byte whose upper seven bits equal {5'b11000, addr_sel_i}, that is 0xC0 + 2*addr_sel_i in 8-bit form with bit 0 as read(1)/write(0). Any other address gets no acknowledge and changes no output.
- R3: In a write, each of the first four data bytes is acknowledged by pulling SDA low during the ninth clock. The pull only starts after an SCL falling edge.
- R4: Data byte 1 bits [6:0] become divider bits [14:8] and data byte 2 becomes divider bits [7:0]. Bit 7 of data byte 1 is ignored.
- R5: In data byte 3, bit 6 sets cp_high_o, bits [5:3] set test_o[2:0], bits [2:1] set ref_sel_o[1:0] and bit 0 sets osc_off_o. Bit 7 is ignored.
- R6: Bits [2:0] of data byte 4 drive band_o[2:0] (bit 0 low VHF band, bit 1 high VHF band, bit 2 UHF band). Bits [7:3] are ignored.
- R7: All settings change together, and only when the acknowledge of data byte 4 ends. A write that ends, by a stop or a repeated start, with fewer than four data bytes leaves every output unchanged.
- R8: Data bytes after the fourth are not acknowledged and have no effect on any output.
- R9: A read returns the status byte MSB first as {power flag, lock_i, acps_i, 1, 1, level_i[2:0]}. The inputs are sampled once, when the byte's first bit is put on the bus, and later changes do not alter that byte.
- R10: The power flag is cleared once a status byte has been sent completely, and it stays 0 until the next reset.
- R11: A master acknowledge after a status byte makes the slave send another status byte, sampled afresh. A master non-acknowledge makes it release SDA until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| sda_pull_o | output | 1 | 1 pulls SDA low (open drain) |
| addr_sel_i | input | 2 | Strap picking one of four slave addresses |
| lock_i | input | 1 | Loop lock indication for the status byte |
| acps_i | input | 1 | Automatic low-current charge pump active |
| level_i | input | 3 | Code from the five-level converter |
| div_o | output | DIV_W | Programmable divider word |
| cp_high_o | output | 1 | Charge pump high-current select |
| test_o | output | 3 | Test mode bits |
| ref_sel_o | output | 2 | Reference divider ratio select |
| osc_off_o | output | 1 | Oscillator disable |
| band_o | output | BAND_N | Band-switch port controls |

## Verification
Two things can meet in the same transfer. The lock, charge-pump and converter inputs can change while a status byte is being shifted out, and the next status byte must then be sampled afresh. The bench changes all three inputs right after the first bit of a status byte has been sampled by the master. It then expects the old values in that whole byte and the new values, with the power flag now clear, in the following byte that the master acknowledged. In the same way a repeated start can land in the middle of a write. The bench checks that the interrupted bytes never reach the outputs and that the full write that follows does.

// File: rtl/tsyn_pkg.sv
package tsyn_pkg;
   localparam int IDX_W = 3;
   localparam logic [IDX_W-1:0] LAST_IDX = 3'd3;
   localparam int LVL_W = 3;

   typedef enum logic [3:0] {
      ST_IDLE, ST_ADDR, ST_AACK, ST_WR, ST_WACK,
      ST_RD, ST_RACK, ST_RLD, ST_SKIP
   } bus_st_t;
endpackage

// File: rtl/tsyn_bus_cond.sv
module tsyn_bus_cond #(
   parameter int SYNC_N = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic sda_lvl,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_det,
   output logic stop_det
);
   logic [SYNC_N-1:0] scl_sh, sda_sh;
   logic scl_d, sda_d, scl_lvl;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_sh <= '1;
         sda_sh <= '1;
         scl_d  <= 1'b1;
         sda_d  <= 1'b1;
      end else begin
         scl_sh <= {scl_sh[SYNC_N-2:0], scl_i};
         sda_sh <= {sda_sh[SYNC_N-2:0], sda_i};
         scl_d  <= scl_sh[SYNC_N-1];
         sda_d  <= sda_sh[SYNC_N-1];
      end
   end

   assign scl_lvl   = scl_sh[SYNC_N-1];
   assign sda_lvl   = sda_sh[SYNC_N-1];
   assign scl_rise  = scl_lvl & ~scl_d;
   assign scl_fall  = ~scl_lvl & scl_d;
   assign start_det = scl_lvl & scl_d & ~sda_lvl & sda_d;
   assign stop_det  = scl_lvl & scl_d & sda_lvl & ~sda_d;
endmodule

// File: rtl/tsyn_i2c_fsm.sv
module tsyn_i2c_fsm
   import tsyn_pkg::*;
#(
   parameter logic [6:0] ADDR_BASE = 7'h60
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sda_lvl,
   input  logic             scl_rise,
   input  logic             scl_fall,
   input  logic             start_det,
   input  logic             stop_det,
   input  logic [1:0]       addr_sel,
   input  logic [7:0]       status,
   output logic             sda_pull,
   output logic             byte_stb,
   output logic [IDX_W-1:0] byte_idx,
   output logic [7:0]       byte_dat,
   output logic             commit_stb,
   output logic             por_clr
);
   bus_st_t          st;
   logic [3:0]       bitn;
   logic             got8;
   logic             rw;
   logic [7:0]       sh;
   logic [7:0]       tx;
   logic [IDX_W-1:0] idx;
   logic [6:0]       my_addr;

   assign my_addr  = {ADDR_BASE[6:2], addr_sel};
   assign byte_idx = idx;
   assign byte_dat = sh;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st         <= ST_IDLE;
         bitn       <= '0;
         got8       <= 1'b0;
         rw         <= 1'b0;
         sh         <= '0;
         tx         <= '0;
         idx        <= '0;
         sda_pull   <= 1'b0;
         byte_stb   <= 1'b0;
         commit_stb <= 1'b0;
         por_clr    <= 1'b0;
      end else begin
         byte_stb   <= 1'b0;
         commit_stb <= 1'b0;
         por_clr    <= 1'b0;
         if (stop_det) begin
            st       <= ST_IDLE;
            got8     <= 1'b0;
            sda_pull <= 1'b0;
         end else if (start_det) begin
            st       <= ST_ADDR;
            bitn     <= '0;
            got8     <= 1'b0;
            idx      <= '0;
            sda_pull <= 1'b0;
         end else begin
            case (st)
               ST_ADDR, ST_WR: begin
                  if (scl_rise) begin
                     sh   <= {sh[6:0], sda_lvl};
                     bitn <= bitn + 4'd1;
                     if (bitn == 4'd7) got8 <= 1'b1;
                  end
                  if (scl_fall && got8) begin
                     got8 <= 1'b0;
                     bitn <= '0;
                     if (st == ST_ADDR) begin
                        if (sh[7:1] == my_addr) begin
                           sda_pull <= 1'b1;
                           rw       <= sh[0];
                           st       <= ST_AACK;
                        end else begin
                           st <= ST_SKIP;
                        end
                     end else if (idx <= LAST_IDX) begin
                        sda_pull <= 1'b1;
                        byte_stb <= 1'b1;
                        st       <= ST_WACK;
                     end else begin
                        st <= ST_SKIP;
                     end
                  end
               end
               ST_AACK: begin
                  if (scl_fall) begin
                     if (rw) begin
                        sda_pull <= ~status[7];
                        tx       <= {status[6:0], 1'b0};
                        st       <= ST_RD;
                     end else begin
                        sda_pull <= 1'b0;
                        st       <= ST_WR;
                     end
                  end
               end
               ST_WACK: begin
                  if (scl_fall) begin
                     sda_pull <= 1'b0;
                     if (idx == LAST_IDX) commit_stb <= 1'b1;
                     idx <= idx + 3'd1;
                     st  <= ST_WR;
                  end
               end
               ST_RD: begin
                  if (scl_rise) begin
                     bitn <= bitn + 4'd1;
                     if (bitn == 4'd7) begin
                        got8    <= 1'b1;
                        por_clr <= 1'b1;
                     end
                  end
                  if (scl_fall) begin
                     if (got8) begin
                        got8     <= 1'b0;
                        bitn     <= '0;
                        sda_pull <= 1'b0;
                        st       <= ST_RACK;
                     end else begin
                        sda_pull <= ~tx[7];
                        tx       <= {tx[6:0], 1'b0};
                     end
                  end
               end
               ST_RACK: begin
                  if (scl_rise) st <= sda_lvl ? ST_SKIP : ST_RLD;
               end
               ST_RLD: begin
                  if (scl_fall) begin
                     sda_pull <= ~status[7];
                     tx       <= {status[6:0], 1'b0};
                     st       <= ST_RD;
                  end
               end
               default: ;
            endcase
         end
      end
   end
endmodule

// File: rtl/tsyn_regs.sv
module tsyn_regs
   import tsyn_pkg::*;
#(
   parameter int DIV_W  = 15,
   parameter int BAND_N = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              byte_stb,
   input  logic [IDX_W-1:0]  byte_idx,
   input  logic [7:0]        byte_dat,
   input  logic              commit_stb,
   input  logic              por_clr,
   output logic [DIV_W-1:0]  div_q,
   output logic              cp_q,
   output logic [2:0]        test_q,
   output logic [1:0]        ref_q,
   output logic              osc_q,
   output logic [BAND_N-1:0] band_q,
   output logic              por_q
);
   localparam int HI_W = DIV_W - 8;

   logic [HI_W-1:0]   s_hi;
   logic [7:0]        s_lo;
   logic [6:0]        s_ctl;
   logic [BAND_N-1:0] s_band;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s_hi   <= '0;
         s_lo   <= '0;
         s_ctl  <= '0;
         s_band <= '0;
      end else if (byte_stb) begin
         case (byte_idx)
            3'd0:    s_hi   <= byte_dat[HI_W-1:0];
            3'd1:    s_lo   <= byte_dat;
            3'd2:    s_ctl  <= byte_dat[6:0];
            3'd3:    s_band <= byte_dat[BAND_N-1:0];
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         div_q  <= '0;
         cp_q   <= 1'b0;
         test_q <= '0;
         ref_q  <= '0;
         osc_q  <= 1'b0;
         band_q <= '0;
      end else if (commit_stb) begin
         div_q  <= {s_hi, s_lo};
         cp_q   <= s_ctl[6];
         test_q <= s_ctl[5:3];
         ref_q  <= s_ctl[2:1];
         osc_q  <= s_ctl[0];
         band_q <= s_band;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       por_q <= 1'b1;
      else if (por_clr) por_q <= 1'b0;
   end
endmodule

// File: rtl/tsyn_ctrl.sv
module tsyn_ctrl
   import tsyn_pkg::*;
#(
   parameter int         DIV_W     = 15,
   parameter int         BAND_N    = 3,
   parameter int         SYNC_N    = 2,
   parameter logic [6:0] ADDR_BASE = 7'h60
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_i,
   input  logic              sda_i,
   output logic              sda_pull_o,
   input  logic [1:0]        addr_sel_i,
   input  logic              lock_i,
   input  logic              acps_i,
   input  logic [LVL_W-1:0]  level_i,
   output logic [DIV_W-1:0]  div_o,
   output logic              cp_high_o,
   output logic [2:0]        test_o,
   output logic [1:0]        ref_sel_o,
   output logic              osc_off_o,
   output logic [BAND_N-1:0] band_o
);
   if (DIV_W < 9 || DIV_W > 15) begin : g_bad_div
      $error("DIV_W must lie in 9..15");
   end
   if (BAND_N < 1 || BAND_N > 5) begin : g_bad_band
      $error("BAND_N must lie in 1..5");
   end
   if (SYNC_N < 2) begin : g_bad_sync
      $error("SYNC_N must be at least 2");
   end
   if (ADDR_BASE[1:0] != 2'b00) begin : g_bad_addr
      $error("ADDR_BASE low two bits are taken by the strap");
   end

   logic             sda_lvl, scl_rise, scl_fall, start_det, stop_det;
   logic             byte_stb, commit_stb, por_clr, por_q;
   logic [IDX_W-1:0] byte_idx;
   logic [7:0]       byte_dat;
   logic [7:0]       status;

   assign status = {por_q, lock_i, acps_i, 2'b11, level_i};

   tsyn_bus_cond #(.SYNC_N(SYNC_N)) u_cond (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
      .sda_lvl(sda_lvl), .scl_rise(scl_rise), .scl_fall(scl_fall),
      .start_det(start_det), .stop_det(stop_det)
   );

   tsyn_i2c_fsm #(.ADDR_BASE(ADDR_BASE)) u_fsm (
      .clk(clk), .rst_n(rst_n), .sda_lvl(sda_lvl),
      .scl_rise(scl_rise), .scl_fall(scl_fall),
      .start_det(start_det), .stop_det(stop_det),
      .addr_sel(addr_sel_i), .status(status),
      .sda_pull(sda_pull_o), .byte_stb(byte_stb), .byte_idx(byte_idx),
      .byte_dat(byte_dat), .commit_stb(commit_stb), .por_clr(por_clr)
   );

   tsyn_regs #(.DIV_W(DIV_W), .BAND_N(BAND_N)) u_regs (
      .clk(clk), .rst_n(rst_n), .byte_stb(byte_stb), .byte_idx(byte_idx),
      .byte_dat(byte_dat), .commit_stb(commit_stb), .por_clr(por_clr),
      .div_q(div_o), .cp_q(cp_high_o), .test_q(test_o), .ref_q(ref_sel_o),
      .osc_q(osc_off_o), .band_q(band_o), .por_q(por_q)
   );
endmodule

// File: rtl/tsyn_ctrl_chk.sv
module tsyn_ctrl_chk #(
   parameter int DIV_W  = 15,
   parameter int BAND_N = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              sda_pull,
   input logic              scl_fall,
   input logic              commit,
   input logic [DIV_W-1:0]  div,
   input logic [BAND_N-1:0] band,
   input logic              por
);
   AST_PULL_AFTER_FALL: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sda_pull) |-> $past(scl_fall)); // R3
   AST_DIV_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !commit |=> $stable(div)); // R7
   AST_BAND_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !commit |=> $stable(band)); // R7
   AST_POR_NO_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      !$rose(por)); // R10
endmodule

bind tsyn_ctrl tsyn_ctrl_chk #(.DIV_W(DIV_W), .BAND_N(BAND_N)) u_chk (
   .clk(clk), .rst_n(rst_n), .sda_pull(sda_pull_o), .scl_fall(scl_fall),
   .commit(commit_stb), .div(div_o), .band(band_o), .por(por_q)
);

// File: tb/tsyn_ctrl_tb.sv
module tsyn_ctrl_tb;
   localparam int HALF = 6;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic scl_m = 1'b1;
   logic sda_m = 1'b1;
   logic sda_bus;
   logic sda_pull;
   logic [1:0] sel = 2'd0;
   logic lock_r = 1'b1, acps_r = 1'b0;
   logic [2:0] level_r = 3'b101;
   logic [14:0] div;
   logic cp_high, osc_off;
   logic [2:0] test_b, band;
   logic [1:0] ref_sel;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   logic [14:0] e_div = '0;
   logic [6:0]  e_ctl = '0;
   logic [2:0]  e_band = '0;

   always #4 clk = ~clk;

   assign sda_bus = sda_m & ~sda_pull;

   tsyn_ctrl u_dut (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus),
      .sda_pull_o(sda_pull), .addr_sel_i(sel), .lock_i(lock_r),
      .acps_i(acps_r), .level_i(level_r), .div_o(div),
      .cp_high_o(cp_high), .test_o(test_b), .ref_sel_o(ref_sel),
      .osc_off_o(osc_off), .band_o(band)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic hp();
      repeat (HALF) @(negedge clk);
   endtask

   task automatic bus_start();
      sda_m = 1'b1; hp(); scl_m = 1'b1; hp();
      sda_m = 1'b0; hp(); scl_m = 1'b0; hp();
   endtask

   task automatic bus_stop();
      sda_m = 1'b0; hp(); scl_m = 1'b1; hp(); sda_m = 1'b1; hp();
   endtask

   task automatic tx_byte(input logic [7:0] b, output bit ack);
      for (int i = 7; i >= 0; i--) begin
         sda_m = b[i]; hp(); scl_m = 1'b1; hp(); scl_m = 1'b0;
      end
      sda_m = 1'b1; hp(); scl_m = 1'b1; hp();
      ack = ~sda_bus;
      scl_m = 1'b0; hp();
   endtask

   task automatic rx_byte(input bit mack, input bit flip, output logic [7:0] b);
      sda_m = 1'b1;
      for (int i = 7; i >= 0; i--) begin
         hp(); scl_m = 1'b1; hp(); b[i] = sda_bus; scl_m = 1'b0;
         if (flip && i == 7) begin
            lock_r = 1'b0; acps_r = 1'b1; level_r = 3'b010;
         end
      end
      sda_m = ~mack; hp(); scl_m = 1'b1; hp(); scl_m = 1'b0; hp();
      sda_m = 1'b1;
   endtask

   // Writes an address byte and n data bytes; returns the acknowledges.
   task automatic wr_txn(input logic [7:0] adr, input int n, input logic [7:0] d0,
                         input logic [7:0] d1, input logic [7:0] d2, input logic [7:0] d3,
                         input logic [7:0] d4, input bit do_stop,
                         output bit a_ack, output logic [4:0] d_ack);
      logic [7:0] d [5];
      bit k;
      d = '{d0, d1, d2, d3, d4};
      d_ack = '0;
      bus_start();
      tx_byte(adr, a_ack);
      if (a_ack) begin
         for (int i = 0; i < n; i++) begin
            tx_byte(d[i], k);
            d_ack[i] = k;
         end
      end
      if (do_stop) bus_stop();
   endtask

   task automatic exp_set(input logic [7:0] d0, input logic [7:0] d1,
                          input logic [7:0] d2, input logic [7:0] d3);
      e_div  = {d0[6:0], d1};
      e_ctl  = d2[6:0];
      e_band = d3[2:0];
   endtask

   task automatic chk_outs(input string req);
      chk({req, " div"}, 32'(div), 32'(e_div));
      chk({req, " ctl"}, 32'({cp_high, test_b, ref_sel, osc_off}), 32'(e_ctl));
      chk({req, " band"}, 32'(band), 32'(e_band));
   endtask

   task automatic t_reset();
      chk("R1 div", 32'(div), 0);
      chk("R1 ctl", 32'({cp_high, test_b, ref_sel, osc_off}), 0);
      chk("R1 band", 32'(band), 0);
      chk("R1 pull", 32'(sda_pull), 0);
   endtask

   task automatic t_status_first();
      bit a;
      logic [7:0] b;
      bus_start();
      tx_byte(8'hC1, a);
      chk("R2 read address ack", 32'(a), 1);
      // inputs change after the first bit: byte stays coherent (R9), power flag set (R10)
      rx_byte(1'b1, 1'b1, b);
      chk("R9 R10 first status", 32'(b), 32'hDD);
      // master acked: fresh sample, power flag now clear (R11, R10)
      rx_byte(1'b0, 1'b0, b);
      chk("R11 second status", 32'(b), 32'h3A);
      chk("R11 released after nack", 32'(sda_pull), 0);
      bus_stop();
   endtask

   task automatic t_write_basic();
      bit a;
      logic [4:0] k;
      wr_txn(8'hC0, 4, 8'h12, 8'h34, 8'hCB, 8'h05, 8'h00, 1'b1, a, k);
      exp_set(8'h12, 8'h34, 8'hCB, 8'h05);
      chk("R2 addr ack", 32'(a), 1);
      chk("R3 data acks", 32'(k), 32'h0F);
      chk("R4 divider", 32'(div), 32'h1234);
      chk("R5 control", 32'({cp_high, test_b, ref_sel, osc_off}), 32'h4B);
      chk("R6 band", 32'(band), 3'b101);
   endtask

   task automatic t_ignored_bits();
      bit a;
      logic [4:0] k;
      wr_txn(8'hC0, 4, 8'hFF, 8'h00, 8'h34, 8'hFA, 8'h00, 1'b1, a, k);
      exp_set(8'hFF, 8'h00, 8'h34, 8'hFA);
      chk("R4 top bit ignored", 32'(div), 32'h7F00);
      chk("R5 control bit7 ignored", 32'({cp_high, test_b, ref_sel, osc_off}), 32'h34);
      chk("R6 band upper ignored", 32'(band), 3'b010);
   endtask

   task automatic t_wrong_addr();
      bit a;
      logic [4:0] k;
      wr_txn(8'hC2, 4, 8'h01, 8'h02, 8'h03, 8'h07, 8'h00, 1'b1, a, k);
      chk("R2 foreign address nack", 32'(a), 0);
      chk_outs("R2 no effect");
   endtask

   task automatic t_strap();
      bit a;
      logic [4:0] k;
      for (int s = 1; s < 4; s++) begin
         sel = 2'(s);
         wr_txn(8'hC0, 4, 8'h11, 8'h11, 8'h11, 8'h01, 8'h00, 1'b1, a, k);
         chk("R2 base address nack under strap", 32'(a), 0);
         wr_txn(8'(8'hC0 + 2 * s), 4, 8'(s), 8'(8'hA0 + s), 8'h80, 8'(s), 8'h00, 1'b1, a, k);
         exp_set(8'(s), 8'(8'hA0 + s), 8'h80, 8'(s));
         chk("R2 strap address ack", 32'(a), 1);
         chk_outs("R2 strap write");
      end
      sel = 2'd0;
   endtask

   task automatic t_partial();
      bit a;
      logic [4:0] k;
      wr_txn(8'hC0, 3, 8'h55, 8'h66, 8'h7F, 8'h00, 8'h00, 1'b1, a, k);
      chk_outs("R7 partial stop");
      wr_txn(8'hC0, 2, 8'h0A, 8'h0B, 8'h00, 8'h00, 8'h00, 1'b0, a, k);
      chk_outs("R7 partial before repeated start");
      wr_txn(8'hC0, 4, 8'h2B, 8'hCD, 8'hFF, 8'h03, 8'h00, 1'b1, a, k);
      exp_set(8'h2B, 8'hCD, 8'hFF, 8'h03);
      chk_outs("R7 full write after restart");
   endtask

   task automatic t_extra();
      bit a;
      logic [4:0] k;
      wr_txn(8'hC0, 5, 8'h01, 8'h23, 8'hC6, 8'h04, 8'h77, 1'b1, a, k);
      exp_set(8'h01, 8'h23, 8'hC6, 8'h04);
      chk("R8 fifth byte nack", 32'(k), 32'h0F);
      chk_outs("R8 extra byte no effect");
   endtask

   task automatic t_status_later();
      bit a;
      logic [7:0] b;
      level_r = 3'b111;
      bus_start();
      tx_byte(8'hC1, a);
      rx_byte(1'b0, 1'b0, b);
      bus_stop();
      chk("R10 flag stays clear", 32'(b), 32'h3F);
   endtask

   initial begin
      repeat (5) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      repeat (5) @(negedge clk);
      t_status_first();
      t_write_basic();
      t_ignored_bits();
      t_wrong_addr();
      t_strap();
      t_partial();
      t_extra();
      t_status_later();
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule